// File: doc/BRIEF.md
# Receive Descriptor Ring Queue Interface

This block sits between a packet queue engine (the producer) and one CPU (the consumer). The producer appends packet descriptors to a circular ring in memory. Software gives the ring as a base address and an entry count. Each descriptor occupies 16 bytes. The block works out where the producer must place the next descriptor, and it gives the CPU the address of the oldest unprocessed one. It also keeps the queue's write and read positions, each as an index plus a wrap flag.

The CPU reads the current-descriptor register, handles that entry, and returns it by writing the entry's address to the finish register. The block reports its occupancy, empty and full states through two status words. It drives an interrupt line that can either follow "queue not empty" or wait until the fill level reaches a programmed threshold. A soft-reset control bit holds the queue empty for as long as it is set.

Top module: `dring_rxq`

## Requirements
- R1: After `rst`, the control register reads 0, the pointer-status word reads 0, the status word reads 0x4000_0000 (only the empty flag set), and `irq` and `q_full` are low.
- R2: The ring base register (select 1) and the entry-count register (select 2) read back the values last written to them.
- R3: An accepted `push` advances the write index by one. When the index passes count-1 it returns to 0 and the write wrap flag toggles. The pointer-status word (select 5) packs the write index in bits 14:0, the write wrap flag in bit 15, the read index in bits 30:16 and the read wrap flag in bit 31. `prod_addr` equals base + write index × 16.
- R4: A `push` while the queue is full is refused and leaves the indices unchanged. Full means the indices are equal and the wrap flags differ. The status word (select 6) shows full in bit 31, and `q_full` is high.
- R5: The status word shows the available count (write position minus read position, modulo twice the ring size) in bits 15:0 and an empty flag in bit 30. Empty means the indices and the wrap flags are both equal.
- R6: The current-pointer register (select 3) reads base + read index × 16. A write to the finish register (select 4) advances the read index, with the same wrap rule as R3, only when its data equals the current pointer and the queue is not empty. Any other finish write changes nothing. A push and a finish in the same cycle both take effect.
- R7: `irq` is registered and follows the state one cycle later. It is low whenever the interrupt enable (control bit 0) is clear. With the enable set and the threshold mode off, `irq` is high whenever the queue is not empty.
- R8: With the threshold mode on (control bit 1) and the enable set, `irq` is high only when the available count is at least the threshold (control bits 31:16). A control write with a zero threshold stores the threshold mode as 0.
- R9: While the soft-reset bit (control bit 2) is set, both indices and both wrap flags are held at 0, pushes and finishes are ignored, and `irq` is low.
- R10: Register writes take effect at the next clock edge. A read returns on `reg_rdata` one edge after `reg_rd`, and the value reflects the state before that edge. Select 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Producer appends one descriptor this cycle |
| q_full | output | 1 | Queue is full; a push now is refused |
| prod_addr | output | AW | Address where the producer writes the next descriptor |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
A push, an accepted finish or a register write changes the queue state at the clock edge that samples it. A read strobe returns its data one edge later. `irq` lags any change of state or control by one further edge. The bench drives every input at a falling edge and reads results at the falling edge that follows the edge they are due on. Each interrupt check first waits one extra edge after the stimulus that changed the state, so it never samples the old value of the interrupt register.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned DESC_SHIFT  = 4;   // 16-byte descriptors
  localparam int unsigned FIELD_W     = 16;  // index/avail/threshold field span
  localparam int unsigned CTL_IRQ_EN  = 0;
  localparam int unsigned CTL_THR_EN  = 1;
  localparam int unsigned CTL_SRST    = 2;
  localparam int unsigned CTL_THR_LSB = 16;
  localparam int unsigned ST_EMPTY    = 30;
  localparam int unsigned ST_FULL     = 31;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_BASE  = 3'd1,
    SEL_COUNT = 3'd2,
    SEL_CUR   = 3'd3,
    SEL_FIN   = 3'd4,
    SEL_PTRS  = 3'd5,
    SEL_STAT  = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/dring_regs.sv
module dring_regs
  import dring_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned THR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [WORD_W-1:0] wdata,
  output logic              irq_en,
  output logic              thr_en,
  output logic              soft_rst,
  output logic [THR_W-1:0]  thr,
  output logic [AW-1:0]     base,
  output logic [CNT_W-1:0]  count
);
  logic [THR_W-1:0] thr_in;
  assign thr_in = wdata[CTL_THR_LSB +: THR_W];

  // Control bits between the soft reset and the threshold, plus the
  // count bits above the entry-count width, are not stored.
  logic unused_wbits;
  assign unused_wbits = ^{wdata[CTL_THR_LSB-1:CTL_SRST+1], wdata[WORD_W-1:CNT_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en   <= 1'b0;
      thr_en   <= 1'b0;
      soft_rst <= 1'b0;
      thr      <= '0;
      base     <= '0;
      count    <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_CTRL: begin
          irq_en   <= wdata[CTL_IRQ_EN];
          thr_en   <= wdata[CTL_THR_EN] && (thr_in != '0);
          soft_rst <= wdata[CTL_SRST];
          thr      <= thr_in;
        end
        SEL_BASE:  base  <= wdata[AW-1:0];
        SEL_COUNT: count <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dring_ptr.sv
module dring_ptr #(
  parameter int unsigned IDX_W = 15,
  parameter int unsigned CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] count,
  output logic [IDX_W-1:0] idx,
  output logic             wrap
);
  logic at_last;
  assign at_last = (CNT_W'(idx) == (count - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx  <= '0;
      wrap <= 1'b0;
    end else if (adv) begin
      if (at_last) begin
        idx  <= '0;
        wrap <= ~wrap;
      end else begin
        idx  <= idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/dring_level.sv
module dring_level #(
  parameter int unsigned IDX_W = 15,
  parameter int unsigned CNT_W = IDX_W + 1,
  parameter int unsigned THR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_wrap,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_wrap,
  input  logic [CNT_W-1:0] count,
  input  logic             irq_en,
  input  logic             thr_en,
  input  logic [THR_W-1:0] thr,
  input  logic             soft_rst,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] avail,
  output logic             irq
);
  logic same_idx, same_lap, want_irq;

  assign same_idx = (wr_idx == rd_idx);
  assign same_lap = (wr_wrap == rd_wrap);
  assign empty    = same_idx && same_lap;
  assign full     = same_idx && !same_lap;

  always_comb begin
    if (same_lap) avail = CNT_W'(wr_idx) - CNT_W'(rd_idx);
    else          avail = count - CNT_W'(rd_idx) + CNT_W'(wr_idx);
  end

  always_comb begin
    if (thr_en) want_irq = (32'(avail) >= 32'(thr));
    else        want_irq = !empty;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_en && !soft_rst && want_irq;
  end
endmodule

// File: rtl/dring_rxq.sv
module dring_rxq
  import dring_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned IDX_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  output logic              q_full,
  output logic [AW-1:0]     prod_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int unsigned CNT_W = IDX_W + 1;
  localparam int unsigned THR_W = FIELD_W;
  localparam int unsigned NPTR  = 2;  // 0: write side, 1: read side

  reg_sel_e         sel;
  logic             irq_en, thr_en, soft_rst;
  logic [THR_W-1:0] thr;
  logic [AW-1:0]    base, cur_ptr;
  logic [CNT_W-1:0] count, avail;
  logic             q_empty, q_full_i;
  logic             push_go, fin_hit, fin_go;
  logic [IDX_W-1:0] idx_q [NPTR];
  logic             wrap_q [NPTR];
  logic             adv [NPTR];
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             wr_wrap, rd_wrap;

  assign sel = reg_sel_e'(reg_sel);

  dring_regs #(.AW(AW), .CNT_W(CNT_W), .THR_W(THR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .sel(sel), .wdata(reg_wdata),
    .irq_en(irq_en), .thr_en(thr_en), .soft_rst(soft_rst), .thr(thr),
    .base(base), .count(count)
  );

  assign push_go = push && !q_full_i && !soft_rst && (count != '0);
  assign fin_hit = reg_wr && (sel == SEL_FIN) && (reg_wdata[AW-1:0] == cur_ptr);
  assign fin_go  = fin_hit && !q_empty && !soft_rst;
  assign adv[0]  = push_go;
  assign adv[1]  = fin_go;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dring_ptr #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptr (
      .clk(clk), .rst(rst), .clr(soft_rst), .adv(adv[g]), .count(count),
      .idx(idx_q[g]), .wrap(wrap_q[g])
    );
  end

  assign wr_idx  = idx_q[0];
  assign wr_wrap = wrap_q[0];
  assign rd_idx  = idx_q[1];
  assign rd_wrap = wrap_q[1];

  dring_level #(.IDX_W(IDX_W), .CNT_W(CNT_W), .THR_W(THR_W)) u_level (
    .clk(clk), .rst(rst), .wr_idx(wr_idx), .wr_wrap(wr_wrap),
    .rd_idx(rd_idx), .rd_wrap(rd_wrap), .count(count), .irq_en(irq_en),
    .thr_en(thr_en), .thr(thr), .soft_rst(soft_rst), .empty(q_empty),
    .full(q_full_i), .avail(avail), .irq(irq)
  );

  assign cur_ptr   = base + (AW'(rd_idx) << DESC_SHIFT);
  assign prod_addr = base + (AW'(wr_idx) << DESC_SHIFT);
  assign q_full    = q_full_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (sel)
        SEL_CTRL:  reg_rdata <= {thr, {(CTL_THR_LSB-CTL_SRST-1){1'b0}},
                                 soft_rst, thr_en, irq_en};
        SEL_BASE:  reg_rdata <= WORD_W'(base);
        SEL_COUNT: reg_rdata <= WORD_W'(count);
        SEL_CUR:   reg_rdata <= WORD_W'(cur_ptr);
        SEL_PTRS:  reg_rdata <= {rd_wrap, (FIELD_W-1)'(rd_idx),
                                 wr_wrap, (FIELD_W-1)'(wr_idx)};
        SEL_STAT:  reg_rdata <= {q_full_i, q_empty, (WORD_W-FIELD_W-2)'(0),
                                 FIELD_W'(avail)};
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dring_rxq_chk.sv
module dring_rxq_chk #(
  parameter int unsigned IDX_W = 15,
  parameter int unsigned CNT_W = IDX_W + 1,
  parameter int unsigned THR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             push,
  input logic             fin_hit,
  input logic             irq_en,
  input logic             thr_en,
  input logic [THR_W-1:0] thr,
  input logic             soft_rst,
  input logic [IDX_W-1:0] wr_idx,
  input logic             wr_wrap,
  input logic [IDX_W-1:0] rd_idx,
  input logic             rd_wrap,
  input logic             q_empty,
  input logic             q_full,
  input logic [CNT_W-1:0] avail,
  input logic [CNT_W-1:0] count,
  input logic             irq
);
  // R5: empty and full never hold together
  a_r5_empty_full_excl: assert property (@(posedge clk) disable iff (rst)
    !(q_empty && q_full));

  // R5: occupancy never exceeds the ring size
  a_r5_avail_bound: assert property (@(posedge clk) disable iff (rst)
    32'(avail) <= 32'(count));

  // R4: a push into a full queue leaves the write side untouched
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (q_full && push) |=> ($stable(wr_idx) && $stable(wr_wrap)));

  // R6: a finish on an empty queue leaves the read side untouched
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (q_empty && fin_hit) |=> ($stable(rd_idx) && $stable(rd_wrap)));

  // R7: no interrupt the cycle after the enable is clear
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);

  // R8: threshold mode is never on with a zero threshold
  a_r8_thr_nonzero: assert property (@(posedge clk) disable iff (rst)
    thr_en |-> (thr != '0));

  // R9: soft reset empties the queue and silences the interrupt
  a_r9_soft_reset: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (wr_idx == '0 && rd_idx == '0 && !wr_wrap && !rd_wrap && !irq));
endmodule

bind dring_rxq dring_rxq_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst(rst), .push(push), .fin_hit(fin_hit), .irq_en(irq_en),
  .thr_en(thr_en), .thr(thr), .soft_rst(soft_rst), .wr_idx(wr_idx),
  .wr_wrap(wr_wrap), .rd_idx(rd_idx), .rd_wrap(rd_wrap), .q_empty(q_empty),
  .q_full(q_full_i), .avail(avail), .count(count), .irq(irq)
);

// File: tb/dring_rxq_test.sv
`timescale 1ns/1ps
module dring_rxq_test;
  localparam logic [2:0] S_CTRL = 3'd0, S_BASE = 3'd1, S_COUNT = 3'd2,
                         S_CUR = 3'd3, S_FIN = 3'd4, S_PTRS = 3'd5, S_STAT = 3'd6;
  localparam logic [31:0] BASE = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        q_full, irq;
  logic [31:0] prod_addr, reg_rdata;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dring_rxq uut (
    .clk(clk), .rst(rst), .push(push), .q_full(q_full), .prod_addr(prod_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] s, input logic [31:0] exp);
    reg_rd = 1'b1; reg_sel = s;
    tick();
    reg_rd = 1'b0;
    chk(req, reg_rdata, exp);
  endtask

  task automatic do_push();
    push = 1'b1;
    tick();
    push = 1'b0;
  endtask

  task automatic push_and_finish(input logic [31:0] a);
    push = 1'b1; reg_wr = 1'b1; reg_sel = S_FIN; reg_wdata = a;
    tick();
    push = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", S_CTRL, 32'h0);
    rd_chk("R1 ptr status", S_PTRS, 32'h0);
    rd_chk("R1 status", S_STAT, 32'h4000_0000);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 q_full", {31'b0, q_full}, 32'h0);
  endtask

  task automatic t_config();
    wr(S_BASE, BASE);
    wr(S_COUNT, 32'd4);
    rd_chk("R2 R10 base readback", S_BASE, BASE);
    rd_chk("R2 R10 count readback", S_COUNT, 32'd4);
    rd_chk("R10 unmapped select", 3'd7, 32'h0);
  endtask

  task automatic t_fill();
    wr(S_CTRL, 32'h1);
    do_push();
    tick();
    chk("R7 irq when non-empty", {31'b0, irq}, 32'h1);
    chk("R3 prod_addr", prod_addr, BASE + 32'h10);
    rd_chk("R5 avail 1", S_STAT, 32'h1);
    for (int i = 0; i < 3; i++) do_push();
    rd_chk("R3 write wrap", S_PTRS, 32'h0000_8000);
    rd_chk("R4 R5 full status", S_STAT, 32'h8000_0004);
    chk("R4 q_full", {31'b0, q_full}, 32'h1);
    chk("R3 prod_addr after wrap", prod_addr, BASE);
    do_push();
    rd_chk("R4 push refused when full", S_PTRS, 32'h0000_8000);
  endtask

  task automatic t_drain();
    rd_chk("R6 current pointer", S_CUR, BASE);
    wr(S_FIN, BASE + 32'h10);
    rd_chk("R6 mismatched finish ignored", S_PTRS, 32'h0000_8000);
    wr(S_FIN, BASE);
    rd_chk("R6 pointer advances", S_CUR, BASE + 32'h10);
    rd_chk("R5 avail 3", S_STAT, 32'h3);
    for (int i = 1; i < 4; i++) wr(S_FIN, BASE + 32'(i * 16));
    rd_chk("R6 read wrap", S_PTRS, 32'h8000_8000);
    rd_chk("R5 empty after drain", S_STAT, 32'h4000_0000);
    tick();
    chk("R7 irq low when empty", {31'b0, irq}, 32'h0);
    wr(S_FIN, BASE);
    rd_chk("R6 finish on empty ignored", S_PTRS, 32'h8000_8000);
  endtask

  task automatic t_thresh();
    wr(S_CTRL, 32'h0003_0003);
    rd_chk("R8 ctrl readback", S_CTRL, 32'h0003_0003);
    do_push(); do_push();
    tick();
    chk("R8 irq below threshold", {31'b0, irq}, 32'h0);
    do_push();
    tick();
    chk("R8 irq at threshold", {31'b0, irq}, 32'h1);
    wr(S_CTRL, 32'h0000_0003);
    rd_chk("R8 zero threshold clears mode", S_CTRL, 32'h0000_0001);
    tick();
    chk("R7 irq non-empty mode", {31'b0, irq}, 32'h1);
    wr(S_CTRL, 32'h0);
    tick();
    chk("R7 irq disabled", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_soft_reset();
    wr(S_CTRL, 32'h4);
    rd_chk("R9 ctrl readback", S_CTRL, 32'h4);
    rd_chk("R9 indices cleared", S_PTRS, 32'h0);
    do_push();
    rd_chk("R9 push ignored", S_STAT, 32'h4000_0000);
    wr(S_CTRL, 32'h1);
    do_push();
    rd_chk("R9 queue runs after release", S_STAT, 32'h1);
    push_and_finish(BASE);
    rd_chk("R6 push and finish together avail", S_STAT, 32'h1);
    rd_chk("R6 push and finish together indices", S_PTRS, 32'h0001_0002);
    tick();
    chk("R7 irq after release", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_config();
    t_fill();
    t_drain();
    t_thresh();
    t_soft_reset();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule